// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a cache controller and a single memory port. Stores and dirty lines evicted by the cache are placed in a small queue of address/data entries and written to memory in the background. The requester therefore never waits for memory on a store. The queue drains in arrival order whenever the memory port is free.

A read miss does not wait for the queue to empty. On acceptance its address is compared with every entry held in the queue. If an entry matches, the data of the youngest match is returned at once, and memory is not read. If nothing matches, the read takes the memory port ahead of every queued write. A read miss may also carry the dirty line it displaces. That victim enters the queue in the cycle the read is accepted, and it is written only after the read has been sent. The response goes back when the read data arrives, without waiting for the victim write.

The read side is a four-state machine. RD_IDLE moves to RD_FWD on *accept-hit* or to RD_ISSUE on *accept-miss*. RD_ISSUE moves to RD_WAIT on *grant*. RD_WAIT returns to RD_IDLE on *data-return*. RD_FWD returns to RD_IDLE on *forward-done*. Arbitration of the memory port is combinational: a waiting read always wins, and otherwise the oldest queue entry is offered.

Top module: `write_bypass_buffer`

## Requirements
- R1: After reset the queue is empty, `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: A store is taken in any cycle where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 when the queue is not full and no victim is being captured in that cycle. While no read is waiting, the oldest entry is offered on the memory port with `mem_req_write`=1.
- R3: A read is taken only in RD_IDLE, where `rd_ready` can be 1. Every taken read produces exactly one response cycle with `rd_resp_valid`=1, and `rd_ready` stays 0 until that response.
- R4: If a taken read matches no entry, the cycle after acceptance carries a memory read (`mem_req_valid`=1, `mem_req_write`=0, its address). No queued write is granted before it. The response appears in the cycle where `mem_rsp_valid` is 1, with `mem_rsp_data` and `rd_resp_fwd`=0.
- R5: If a taken read matches entries present before its accepting edge, the data of the youngest match is returned in the cycle after acceptance with `rd_resp_fwd`=1, and no memory read is issued. A store taken in the same edge counts as younger than the read.
- R6: A read with `rd_evict`=1 pushes the victim into the queue at its accepting edge. The read is granted memory before the victim write, and the response is delivered before the victim write is granted.
- R7: Entries leave in arrival order, so after draining, memory holds the value of the latest store to each address.
- R8: With the queue full, `wr_ready` is 0. A read without a victim is still taken and serviced. A read with a victim is held (`rd_ready`=0).
- R9: While no read is waiting, exactly one entry leaves per cycle with `mem_req_ready`=1 and `mem_req_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Store or eviction write offered |
| wr_ready | output | 1 | Store taken this cycle when high |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read miss taken this cycle when high |
| rd_addr | input | ADDR_W | Read miss address |
| rd_evict | input | 1 | Read carries a dirty victim |
| rd_evict_addr | input | ADDR_W | Victim address |
| rd_evict_data | input | DATA_W | Victim data |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | DATA_W | Read data |
| rd_resp_fwd | output | 1 | Data came from the queue |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory grants the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
Each result has a fixed due cycle.
- A store has entered the queue one edge after it is offered with `wr_ready` high, and the head entry is visible on the memory port from then on.
- A forwarded read answers in the cycle right after its accepting edge. The bench checks `rd_resp_*` at the falling edge that follows.
- A read miss shows its memory request in that same cycle. Its response shares the cycle of `mem_rsp_valid`.

The bench memory model logs each granted request in grant order, and a monitor notes how many grants preceded each response. This lets checks on priority, ordering and victim timing compare log positions instead of guessing cycle offsets.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2,
        RD_FWD   = 2'd3
    } rd_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_READ  = 2'd1,
        SRC_WRITE = 2'd2
    } mem_src_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  live_q;
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEPTH-1:0]  match_vec;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            live_q <= '0;
        end else begin
            if (pop) begin
                live_q[head_q] <= 1'b0;
                head_q         <= bump(head_q);
            end
            if (push) begin
                addr_q[tail_q] <= push_addr;
                data_q[tail_q] <= push_data;
                live_q[tail_q] <= 1'b1;
                tail_q         <= bump(tail_q);
            end
            if (push && !pop)
                cnt_q <= cnt_q + 1'b1;
            else if (pop && !push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == FULL_CNT);
    assign head_addr = addr_q[head_q];
    assign head_data = data_q[head_q];

    // One comparator per slot
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
            assign match_vec[g] = live_q[g] && (addr_q[g] == look_addr);
        end
    endgenerate

    // Walk slots oldest to youngest; the last hit wins
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int slot;
            slot = int'(head_q) + k;
            if (slot >= DEPTH)
                slot = slot - DEPTH;
            if (match_vec[PTR_W'(slot)]) begin
                look_hit  = 1'b1;
                look_data = data_q[PTR_W'(slot)];
            end
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q != FULL_CNT) || pop);

    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

    assert_count_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wbuf_rd_ctl.sv
module wbuf_rd_ctl
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_evict,
    output logic              rd_ready,
    output logic              rd_accept,
    input  logic              buf_full,
    input  logic              buf_hit,
    input  logic [DATA_W-1:0] buf_hit_data,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_grant,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              rd_resp_fwd
);
    rd_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] fwd_q;

    assign rd_ready  = (state_q == RD_IDLE) && (!rd_evict || !buf_full);
    assign rd_accept = rd_valid && rd_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_accept) state_d = buf_hit ? RD_FWD : RD_ISSUE;
            RD_ISSUE: if (mem_rd_grant) state_d = RD_WAIT;
            RD_WAIT:  if (mem_rsp_valid) state_d = RD_IDLE;
            RD_FWD:   state_d = RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            addr_q  <= '0;
            fwd_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_accept) begin
                addr_q <= rd_addr;
                fwd_q  <= buf_hit_data;
            end
        end
    end

    always_comb begin
        mem_rd_req    = 1'b0;
        rd_resp_valid = 1'b0;
        rd_resp_data  = '0;
        rd_resp_fwd   = 1'b0;
        unique case (state_q)
            RD_IDLE:  ;
            RD_ISSUE: mem_rd_req = 1'b1;
            RD_WAIT: begin
                rd_resp_valid = mem_rsp_valid;
                rd_resp_data  = mem_rsp_data;
            end
            RD_FWD: begin
                rd_resp_valid = 1'b1;
                rd_resp_data  = fwd_q;
                rd_resp_fwd   = 1'b1;
            end
            default: ;
        endcase
    end
    assign mem_rd_addr = addr_q;

    assert_accept_leaves_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |=> !rd_ready);

    assert_single_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_resp_valid |=> !rd_resp_valid);

    assert_hit_skips_memory_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && buf_hit) |=> (!mem_rd_req && rd_resp_valid && rd_resp_fwd));

    assert_miss_requests_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_accept && !buf_hit) |=> mem_rd_req);
endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_avail,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              mem_req_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic              rd_grant,
    output logic              wr_pop
);
    mem_src_e src;

    always_comb begin
        if (rd_req)
            src = SRC_READ;
        else if (wr_avail)
            src = SRC_WRITE;
        else
            src = SRC_NONE;
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        rd_grant      = 1'b0;
        wr_pop        = 1'b0;
        unique case (src)
            SRC_NONE: ;
            SRC_READ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = rd_addr;
                rd_grant      = mem_req_ready;
            end
            SRC_WRITE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = head_addr;
                mem_req_wdata = head_data;
                wr_pop        = mem_req_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/write_bypass_buffer.sv
module write_bypass_buffer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_evict,
    input  logic [ADDR_W-1:0] rd_evict_addr,
    input  logic [DATA_W-1:0] rd_evict_data,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              rd_resp_fwd,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    logic              rd_accept, evict_push, store_push, push, pop;
    logic              buf_full, buf_empty, buf_hit, rd_req, rd_grant;
    logic [ADDR_W-1:0] push_addr, head_addr, rd_req_addr;
    logic [DATA_W-1:0] push_data, head_data, buf_hit_data;

    assign evict_push = rd_accept && rd_evict;
    assign wr_ready   = !buf_full && !evict_push;
    assign store_push = wr_valid && wr_ready;
    assign push       = evict_push || store_push;
    assign push_addr  = evict_push ? rd_evict_addr : wr_addr;
    assign push_data  = evict_push ? rd_evict_data : wr_data;

    wbuf_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (push_addr),
        .push_data (push_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .empty     (buf_empty),
        .full      (buf_full),
        .look_addr (rd_addr),
        .look_hit  (buf_hit),
        .look_data (buf_hit_data)
    );

    wbuf_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_valid      (rd_valid),
        .rd_addr       (rd_addr),
        .rd_evict      (rd_evict),
        .rd_ready      (rd_ready),
        .rd_accept     (rd_accept),
        .buf_full      (buf_full),
        .buf_hit       (buf_hit),
        .buf_hit_data  (buf_hit_data),
        .mem_rd_req    (rd_req),
        .mem_rd_addr   (rd_req_addr),
        .mem_rd_grant  (rd_grant),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data),
        .rd_resp_fwd   (rd_resp_fwd)
    );

    wbuf_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .rd_req        (rd_req),
        .rd_addr       (rd_req_addr),
        .wr_avail      (!buf_empty),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_grant      (rd_grant),
        .wr_pop        (pop)
    );

    assert_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !pop);

    assert_full_blocks_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> !store_push);

    assert_victim_queued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evict_push |=> !buf_empty);
endmodule

// File: tb/tb_write_bypass_buffer.sv
module tb_write_bypass_buffer;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0, rd_valid = 1'b0, rd_evict = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, rd_evict_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_evict_data = '0;
    logic          wr_ready, rd_ready, rd_resp_valid, rd_resp_fwd;
    logic [DW-1:0] rd_resp_data;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid;
    logic [DW-1:0] mem_rsp_data;

    always #10 clk = ~clk;

    write_bypass_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_evict(rd_evict), .rd_evict_addr(rd_evict_addr), .rd_evict_data(rd_evict_data),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .rd_resp_fwd(rd_resp_fwd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory model with a grant log
    logic [DW-1:0] mem_q [16];
    logic          op_wr   [64];
    logic [AW-1:0] op_addr [64];
    logic [DW-1:0] op_data [64];
    int            op_cnt = 0;
    int            resp_cnt = 0, resp_at_op = 0;
    logic [DW-1:0] resp_last = '0;

    initial for (int i = 0; i < 16; i++) mem_q[i] = 32'hA000_0000 + i;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_data  <= '0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (op_cnt < 64) begin
                op_wr[op_cnt]   <= mem_req_write;
                op_addr[op_cnt] <= mem_req_addr;
                op_data[op_cnt] <= mem_req_wdata;
            end
            op_cnt <= op_cnt + 1;
            if (mem_req_write)
                mem_q[mem_req_addr[3:0]] <= mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem_q[mem_req_addr[3:0]];
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && rd_resp_valid) begin
            resp_cnt   <= resp_cnt + 1;
            resp_at_op <= op_cnt;
            resp_last  <= rd_resp_data;
        end
    end

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic issue_read(input logic [AW-1:0] a, input logic ev,
                              input logic [AW-1:0] ea, input logic [DW-1:0] ed);
        rd_addr = a; rd_evict = ev; rd_evict_addr = ea; rd_evict_data = ed;
        rd_valid = 1'b1;
        while (!rd_ready) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0; rd_evict = 1'b0;
    endtask

    task automatic wait_resp(input int base);
        for (int i = 0; i < 50 && resp_cnt == base; i++) @(negedge clk);
        check(resp_cnt == base + 1, "R3", "one response per read", resp_cnt, base + 1);
    endtask

    task automatic t_reset;
        check(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
        check(rd_ready == 1'b1, "R1", "rd_ready after reset", rd_ready, 1);
        check(mem_req_valid == 1'b0, "R1", "no memory request", mem_req_valid, 0);
        check(rd_resp_valid == 1'b0, "R1", "no response", rd_resp_valid, 0);
    endtask

    task automatic t_store;
        int start;
        mem_req_ready = 1'b0;
        start = op_cnt;
        push_store(16'd3, 32'h111);
        check(mem_req_valid && mem_req_write, "R2", "head offered as write",
              {mem_req_valid, mem_req_write}, 2'b11);
        check(mem_req_addr == 16'd3, "R2", "head address", mem_req_addr, 3);
        mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_q[3] == 32'h111, "R2", "store reached memory", mem_q[3], 32'h111);
        check(op_cnt == start + 1, "R9", "single drain", op_cnt, start + 1);
    endtask

    task automatic t_bypass;
        int start, rb;
        mem_req_ready = 1'b0;
        push_store(16'd5, 32'h55);
        push_store(16'd6, 32'h66);
        start = op_cnt; rb = resp_cnt;
        issue_read(16'd9, 1'b0, '0, '0);
        check(mem_req_valid && !mem_req_write && mem_req_addr == 16'd9, "R4",
              "read request ahead of writes", {mem_req_write, mem_req_addr}, 16'd9);
        mem_req_ready = 1'b1;
        wait_resp(rb);
        check(resp_last == 32'hA000_0009, "R4", "miss data", resp_last, 32'hA000_0009);
        check(!op_wr[start] && op_addr[start] == 16'd9, "R4", "first grant is the read",
              op_addr[start], 9);
        repeat (5) @(negedge clk);
        check(op_cnt == start + 3, "R9", "writes drained after read", op_cnt, start + 3);
    endtask

    task automatic t_forward;
        int start;
        mem_req_ready = 1'b0;
        push_store(16'd7, 32'h71);
        push_store(16'd7, 32'h72);
        push_store(16'd8, 32'h81);
        start = op_cnt;
        issue_read(16'd7, 1'b0, '0, '0);
        check(rd_resp_valid && rd_resp_fwd, "R5", "forward next cycle",
              {rd_resp_valid, rd_resp_fwd}, 2'b11);
        check(rd_resp_data == 32'h72, "R5", "youngest match", rd_resp_data, 32'h72);
        @(negedge clk);
        check(!mem_req_valid || mem_req_write, "R5", "no memory read on hit",
              mem_req_write, 1);
        mem_req_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(op_cnt == start + 3, "R5", "only writes granted", op_cnt, start + 3);
        check(op_data[start] == 32'h71 && op_data[start+1] == 32'h72, "R7",
              "same-address order", op_data[start+1], 32'h72);
        check(mem_q[7] == 32'h72, "R7", "latest value kept", mem_q[7], 32'h72);
    endtask

    task automatic t_evict;
        int start, rb;
        mem_req_ready = 1'b0;
        start = op_cnt; rb = resp_cnt;
        issue_read(16'd10, 1'b1, 16'd11, 32'hE11);
        mem_req_ready = 1'b1;
        wait_resp(rb);
        check(resp_last == 32'hA000_000A, "R6", "read data", resp_last, 32'hA000_000A);
        check(resp_at_op == start + 1, "R6", "response before victim write",
              resp_at_op, start + 1);
        repeat (3) @(negedge clk);
        check(!op_wr[start] && op_addr[start] == 16'd10, "R6", "read granted first",
              op_addr[start], 10);
        check(op_wr[start+1] && op_addr[start+1] == 16'd11 && op_data[start+1] == 32'hE11,
              "R6", "victim written after", op_data[start+1], 32'hE11);
    endtask

    task automatic t_full;
        int start, rb;
        mem_req_ready = 1'b0;
        push_store(16'd0, 32'hF0);
        push_store(16'd1, 32'hF1);
        push_store(16'd2, 32'hF2);
        push_store(16'd4, 32'hF4);
        check(wr_ready == 1'b0, "R8", "wr_ready low when full", wr_ready, 0);
        rd_addr = 16'd13; rd_evict = 1'b1; rd_valid = 1'b1;
        #1;
        check(rd_ready == 1'b0, "R8", "victim read held when full", rd_ready, 0);
        rd_evict = 1'b0;
        #1;
        check(rd_ready == 1'b1, "R8", "plain read taken when full", rd_ready, 1);
        rd_valid = 1'b0;
        @(negedge clk);
        start = op_cnt; rb = resp_cnt;
        issue_read(16'd12, 1'b0, '0, '0);
        mem_req_ready = 1'b1;
        wait_resp(rb);
        check(resp_last == 32'hA000_000C, "R8", "read served while full",
              resp_last, 32'hA000_000C);
        repeat (6) @(negedge clk);
        check(op_cnt == start + 5, "R9", "all entries drained", op_cnt, start + 5);
        check(op_addr[start+1] == 16'd0 && op_addr[start+2] == 16'd1 &&
              op_addr[start+3] == 16'd2 && op_addr[start+4] == 16'd4, "R7",
              "arrival order", op_addr[start+4], 4);
    endtask

    task automatic t_one_per_grant;
        int start;
        mem_req_ready = 1'b0;
        push_store(16'd14, 32'hE0);
        push_store(16'd15, 32'hE1);
        start = op_cnt;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        check(op_cnt == start + 1, "R9", "one entry per grant", op_cnt, start + 1);
        mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_q[15] == 32'hE1, "R9", "rest drained", mem_q[15], 32'hE1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_bypass();
        t_forward();
        t_evict();
        t_full();
        t_one_per_grant();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule